// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external 16-bit asynchronous static RAM with separate lower and upper byte strobes. It takes one single-word read or write at a time through a request/ready handshake. It registers the address, the byte enables and the write data when it accepts the request. It then plays out a strobe sequence on the memory pins whose phase lengths are whole clock cycles set by parameters.

A read holds chip select and output enable low with write enable high until the access time has elapsed. The block samples the bus on the clock edge that ends that count and returns the word with a one-cycle valid pulse. A write first drives the data bus with output enable high. It then pulses write enable low for the longer of the write-pulse and data-setup counts. Every access ends with a turnaround in which the chip is deselected, all strobes are high and the bus is released. This gives the device time to stop driving, satisfies the cycle time, and leaves the RAM in standby whenever the host is idle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and right after it, chip select, output enable, write enable and both byte strobes are high, the bus driver is off, ready is high and read-valid is low.
- R2: Ready drops on the edge that accepts a request and stays low until the controller is idle again. Host address, data and enables that change after acceptance have no effect on the memory address or on the data written or returned.
- R3: A read keeps chip select and output enable low with write enable high for exactly max(address access, output-enable access) cycles, which is 14 by default. It samples the bus on the edge that ends that window. The valid pulse is one cycle long, appears at that same edge, and no valid pulse follows a write.
- R4: Byte enable bit 0 drives the lower strobe (data bits 7..0) and bit 1 the upper strobe (bits 15..8), both active low and only while chip select is low. A lane whose enable is 0 is neither written, nor does its read data leave the controller: its returned byte is 0x00.
- R5: During a write, output enable stays high throughout. The bus is driven from the first write cycle, one setup cycle before write enable falls. Write enable is low for max(write pulse, data setup) cycles, 10 by default.
- R6: The controller never drives the data bus while output enable is low.
- R7: After every access, chip select, write enable and output enable are high and the bus is released for the turnaround count (5 by default) before ready returns. A read therefore takes 19 cycles from acceptance to ready and a write 16.
- R8: Whenever ready is high, chip select and both byte strobes are high, so the RAM sits in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, taken when hostReady is high |
| hostReady | output | 1 | Controller idle and able to accept a request |
| hostWrite | input | 1 | 1 selects a write, 0 a read |
| hostAddr | input | 17 | Word address |
| hostWdata | input | 16 | Write data |
| hostBe | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| hostRdata | output | 16 | Read data, disabled lanes zero |
| hostRvalid | output | 1 | One-cycle pulse marking hostRdata valid |
| memAddr | output | 17 | Memory address |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memDqOut | output | 16 | Data toward the memory |
| memDqIn | input | 16 | Data from the memory |
| memDqOe | output | 1 | Enables the bus driver for memDqOut |

## Verification
Two functions can fall on one clock edge: the edge that ends the read window samples the bus, and the same edge deselects the chip and raises output enable. A wrong order or an extra register would either sample released or still-settling data, or leave the strobes low into the turnaround. The bench provokes this with a memory model that returns a poison word until the access window is complete and a filler byte on any unstrobed lane. It then checks that the returned word is exact, that the valid pulse lands on the cycle the requirements give, and that chip select is already high when it does. Writes that alter one lane are read back with every enable combination, so a stray lane update or a missing mask shows as a wrong byte.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_WAIT,
    ST_READ_CAPTURE,
    ST_WRITE_SETUP,
    ST_WRITE_PULSE,
    ST_TURNAROUND
  } state_e;

  // Intents passed from the sequencer to the datapath.
  // load and capture act on the current edge; the pin intents describe
  // the state being entered so the datapath can register the pins.
  typedef struct packed {
    logic load;
    logic capture;
    logic selChip;
    logic readEn;
    logic writeEn;
    logic driveBus;
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int ADDR_ACC_CYC   = 14,
  parameter int OE_ACC_CYC     = 7,
  parameter int WE_PULSE_CYC   = 10,
  parameter int DATA_SETUP_CYC = 7,
  parameter int SETUP_CYC      = 1,
  parameter int TURN_CYC       = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  logic    hostWrite,
  output logic    hostReady,
  output strobe_t strobes
);

  localparam int READ_CYC  = maxOf(ADDR_ACC_CYC, OE_ACC_CYC);
  localparam int PULSE_CYC = maxOf(WE_PULSE_CYC, DATA_SETUP_CYC);
  localparam int CNT_MAX   = maxOf(maxOf(READ_CYC, PULSE_CYC), maxOf(SETUP_CYC, TURN_CYC));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int READ_WAIT_LOAD = (READ_CYC >= 2) ? READ_CYC - 2 : 0;

  state_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (hostReq) begin
          if (hostWrite) begin
            stateNext = ST_WRITE_SETUP;
            cntNext   = CNT_W'(SETUP_CYC - 1);
          end else if (READ_CYC >= 2) begin
            stateNext = ST_READ_WAIT;
            cntNext   = CNT_W'(READ_WAIT_LOAD);
          end else begin
            stateNext = ST_READ_CAPTURE;
          end
        end
      end
      ST_READ_WAIT: begin
        if (cnt == '0) stateNext = ST_READ_CAPTURE;
        else           cntNext   = cnt - 1'b1;
      end
      ST_READ_CAPTURE: begin
        stateNext = ST_TURNAROUND;
        cntNext   = CNT_W'(TURN_CYC - 1);
      end
      ST_WRITE_SETUP: begin
        if (cnt == '0) begin
          stateNext = ST_WRITE_PULSE;
          cntNext   = CNT_W'(PULSE_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WRITE_PULSE: begin
        if (cnt == '0) begin
          stateNext = ST_TURNAROUND;
          cntNext   = CNT_W'(TURN_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURNAROUND: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign hostReady = (state == ST_IDLE);

  always_comb begin
    strobes.load     = hostReq && (state == ST_IDLE);
    strobes.capture  = (state == ST_READ_CAPTURE);
    strobes.selChip  = stateNext inside {ST_READ_WAIT, ST_READ_CAPTURE,
                                         ST_WRITE_SETUP, ST_WRITE_PULSE};
    strobes.readEn   = stateNext inside {ST_READ_WAIT, ST_READ_CAPTURE};
    strobes.writeEn  = (stateNext == ST_WRITE_PULSE);
    strobes.driveBus = stateNext inside {ST_WRITE_SETUP, ST_WRITE_PULSE};
  end

  // R2: accepting a request takes the controller out of idle
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && hostReady) |=> !hostReady);

  // R3: the sample edge occurs once per read
  assert_capture_once_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);

  // R7: no access is accepted straight out of a strobe phase
  assert_turn_before_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_READ_CAPTURE, ST_WRITE_PULSE}) |=> !hostReady);

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W/8-1:0] hostBe,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W/8-1:0] memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memDqOe
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [LANES-1:0]  beReg, beNext, laneNext;
  logic [DATA_W-1:0] laneData;

  assign beNext = strobes.load ? hostBe : beReg;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneNext[g]         = !(strobes.selChip && beNext[g]);
    assign laneData[g*8 +: 8]  = beReg[g] ? memDqIn[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg    <= '0;
      wdataReg   <= '0;
      beReg      <= '0;
      memCeN     <= 1'b1;
      memOeN     <= 1'b1;
      memWeN     <= 1'b1;
      memLaneN   <= '1;
      memDqOe    <= 1'b0;
      hostRdata  <= '0;
      hostRvalid <= 1'b0;
    end else begin
      if (strobes.load) begin
        addrReg  <= hostAddr;
        wdataReg <= hostWdata;
      end
      beReg      <= beNext;
      memCeN     <= !strobes.selChip;
      memOeN     <= !strobes.readEn;
      memWeN     <= !strobes.writeEn;
      memLaneN   <= laneNext;
      memDqOe    <= strobes.driveBus;
      hostRvalid <= strobes.capture;
      if (strobes.capture) hostRdata <= laneData;
    end
  end

  assign memAddr  = addrReg;
  assign memDqOut = wdataReg;

  // R6: never drive while the device may drive
  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  // R5: output enable stays off while write enable is low
  assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R4: a byte strobe is only low inside a chip-selected cycle
  assert_lane_needs_chip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memLaneN != '1) |-> !memCeN);

  // R2: address is held for the whole selected window
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R3: read data is handed over once the chip is already deselected
  assert_valid_deselected_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostRvalid |-> (memCeN && memOeN));

  // R7: bus stays released in the cycle after output enable was low
  assert_turn_no_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(!memOeN) |-> !memDqOe);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 16,
  parameter int ADDR_ACC_CYC   = 14,
  parameter int OE_ACC_CYC     = 7,
  parameter int WE_PULSE_CYC   = 10,
  parameter int DATA_SETUP_CYC = 7,
  parameter int SETUP_CYC      = 1,
  parameter int TURN_CYC       = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReq,
  output logic                hostReady,
  input  logic                hostWrite,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [DATA_W/8-1:0] hostBe,
  output logic [DATA_W-1:0]   hostRdata,
  output logic                hostRvalid,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memOeN,
  output logic                memWeN,
  output logic                memLbN,
  output logic                memUbN,
  output logic [DATA_W-1:0]   memDqOut,
  input  logic [DATA_W-1:0]   memDqIn,
  output logic                memDqOe
);

  localparam int LANES = DATA_W / 8;

  strobe_t          strobes;
  logic [LANES-1:0] laneN;

  asram_fsm #(
    .ADDR_ACC_CYC  (ADDR_ACC_CYC),
    .OE_ACC_CYC    (OE_ACC_CYC),
    .WE_PULSE_CYC  (WE_PULSE_CYC),
    .DATA_SETUP_CYC(DATA_SETUP_CYC),
    .SETUP_CYC     (SETUP_CYC),
    .TURN_CYC      (TURN_CYC)
  ) uFsm (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostReady(hostReady),
    .strobes  (strobes)
  );

  asram_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostBe    (hostBe),
    .hostRdata (hostRdata),
    .hostRvalid(hostRvalid),
    .memAddr   (memAddr),
    .memCeN    (memCeN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memLaneN  (laneN),
    .memDqOut  (memDqOut),
    .memDqIn   (memDqIn),
    .memDqOe   (memDqOe)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

  // R8: idle means standby on the memory pins
  assert_standby_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (memCeN && memLbN && memUbN));

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int ACC = 14, OEA = 7, WP = 10, DS = 7, SU = 1, TA = 5;
  localparam int READ_T  = (ACC > OEA) ? ACC : OEA;
  localparam int PULSE_T = (WP > DS) ? WP : DS;

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 17'h00012, 2'b11, 16'hA5C3, 16'h0000},
    '{1'b0, 17'h00012, 2'b11, 16'h0000, 16'hA5C3},
    '{1'b1, 17'h00012, 2'b01, 16'h1177, 16'h0000},
    '{1'b0, 17'h00012, 2'b11, 16'h0000, 16'hA577},
    '{1'b1, 17'h00012, 2'b10, 16'h9900, 16'h0000},
    '{1'b0, 17'h00012, 2'b10, 16'h0000, 16'h9900},
    '{1'b0, 17'h00012, 2'b01, 16'h0000, 16'h0077},
    '{1'b1, 17'h1FF34, 2'b11, 16'h0F0F, 16'h0000},
    '{1'b0, 17'h1FF34, 2'b11, 16'h0000, 16'h0F0F},
    '{1'b0, 17'h00099, 2'b11, 16'h0000, 16'h0000},
    '{1'b1, 17'h00050, 2'b00, 16'hFFFF, 16'h0000},
    '{1'b0, 17'h00050, 2'b11, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReq = 1'b0, hostWrite = 1'b0;
  logic [16:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [1:0]  hostBe = '0;
  logic hostReady, hostRvalid;
  logic [15:0] hostRdata;
  logic [16:0] memAddr;
  logic memCeN, memOeN, memWeN, memLbN, memUbN, memDqOe;
  logic [15:0] memDqOut, memDqIn;

  always #2 clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostReady(hostReady),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostBe(hostBe), .hostRdata(hostRdata), .hostRvalid(hostRvalid),
    .memAddr(memAddr), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memLbN(memLbN), .memUbN(memUbN), .memDqOut(memDqOut), .memDqIn(memDqIn),
    .memDqOe(memDqOe)
  );

  int nChecks = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [256] = '{default: 16'h0000};
  function automatic logic [7:0] idx(input logic [16:0] a);
    return a[7:0] ^ a[16:9];
  endfunction

  int accCnt = 0;
  always @(posedge clk) accCnt <= (!memCeN && !memOeN && memWeN) ? accCnt + 1 : 0;

  always_comb begin
    if (!memCeN && !memOeN && memWeN) begin
      memDqIn = (accCnt >= READ_T - 1) ? mem[idx(memAddr)] : 16'hDEAD;
      if (memLbN) memDqIn[7:0]  = 8'hEE;
      if (memUbN) memDqIn[15:8] = 8'hEE;
    end else begin
      memDqIn = 16'hBEEF;
    end
  end

  logic [1:0]  curBe = '0;
  int pulseLen = 0;
  int vioContend = 0, vioOe = 0, vioPulse = 0, vioSetup = 0, vioLane = 0, vioStandby = 0;
  logic prevWeN = 1'b1, prevDqOe = 1'b0, prevLbN = 1'b1, prevUbN = 1'b1;
  logic [16:0] prevAddr = '0;
  logic [15:0] prevDq = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (memDqOe && !memOeN) vioContend++;
      if (!memWeN && !memOeN) vioOe++;
      if (!memWeN && prevWeN && !prevDqOe) vioSetup++;
      if (!memWeN) begin
        pulseLen++;
        if (!memDqOe) vioSetup++;
      end else if (pulseLen > 0) begin
        if (pulseLen != PULSE_T) vioPulse++;
        if (!prevLbN) mem[idx(prevAddr)][7:0]  = prevDq[7:0];
        if (!prevUbN) mem[idx(prevAddr)][15:8] = prevDq[15:8];
        pulseLen = 0;
      end
      if (!memCeN && ({memUbN, memLbN} != ~curBe)) vioLane++;
      if (hostReady && !(memCeN && memLbN && memUbN)) vioStandby++;
    end
    prevWeN  = memWeN;
    prevDqOe = memDqOe;
    prevLbN  = memLbN;
    prevUbN  = memUbN;
    prevAddr = memAddr;
    prevDq   = memDqOut;
  end

  // ---------------- stimulus ----------------
  task automatic runOp(input vec_t v);
    int n = 0, rvN = 0, readyN = 0, extra = 0;
    logic [15:0] got = '0;
    logic [16:0] addrSeen = '0;
    @(negedge clk);
    hostReq = 1'b1; hostWrite = v.wr; hostAddr = v.addr;
    hostBe = v.be; hostWdata = v.wd; curBe = v.be;
    @(posedge clk);
    #1;
    hostReq = 1'b0; hostAddr = ~v.addr; hostWdata = ~v.wd; hostBe = ~v.be;
    while (readyN == 0 && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 3) addrSeen = memAddr;
      if (hostRvalid) begin
        if (rvN == 0) begin rvN = n; got = hostRdata; end
        else extra++;
      end
      if (hostReady) readyN = n;
    end
    check(addrSeen == v.addr, "R2 address held", 32'(addrSeen), 32'(v.addr));
    if (v.wr) begin
      check(rvN == 0, "R3 no valid on write", rvN, 0);
      check(readyN == SU + PULSE_T + TA + 1, "R7 write ready cycle", readyN, SU + PULSE_T + TA + 1);
    end else begin
      check(rvN == READ_T + 1, "R3 valid cycle", rvN, READ_T + 1);
      check(extra == 0, "R3 single valid", extra, 0);
      check(got == v.exp, "R4 read data", 32'(got), 32'(v.exp));
      check(readyN == READ_T + TA + 1, "R7 read ready cycle", readyN, READ_T + TA + 1);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check({memCeN, memOeN, memWeN, memLbN, memUbN} == 5'b11111, "R1 strobes in reset",
          32'({memCeN, memOeN, memWeN, memLbN, memUbN}), 32'h1F);
    check(!memDqOe && !hostRvalid, "R1 driver and valid in reset", 32'({memDqOe, hostRvalid}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(hostReady, "R1 ready after reset", 32'(hostReady), 1);
    check({memCeN, memLbN, memUbN} == 3'b111, "R8 standby after reset",
          32'({memCeN, memLbN, memUbN}), 32'h7);

    for (int i = 0; i < 12; i++) runOp(VEC[i]);

    // R1: reset in the middle of a read returns the pins to idle
    @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 17'h00012; hostBe = 2'b11; curBe = 2'b11;
    @(posedge clk);
    #1 hostReq = 1'b0;
    repeat (4) @(negedge clk);
    check(!memCeN && !memOeN, "R3 read strobes active", 32'({memCeN, memOeN}), 0);
    rstN = 1'b0;
    #1;
    check({memCeN, memOeN, memWeN, memLbN, memUbN} == 5'b11111, "R1 strobes after mid reset",
          32'({memCeN, memOeN, memWeN, memLbN, memUbN}), 32'h1F);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hostReady && !hostRvalid, "R1 idle after mid reset", 32'({hostReady, hostRvalid}), 32'h2);
    runOp('{1'b0, 17'h00012, 2'b11, 16'h0000, 16'h9977});

    repeat (3) @(negedge clk);
    check(vioContend == 0, "R6 bus contention", vioContend, 0);
    check(vioOe == 0, "R5 output enable during write", vioOe, 0);
    check(vioPulse == 0, "R5 write pulse length", vioPulse, 0);
    check(vioSetup == 0, "R5 data driven before and during pulse", vioSetup, 0);
    check(vioLane == 0, "R4 lane strobes follow enables", vioLane, 0);
    check(vioStandby == 0, "R8 standby while idle", vioStandby, 0);
    finishRun();
  end

endmodule